// File: doc/BRIEF.md
# Power-Up Delay Sequencer

After power-on, this block keeps the rest of the device in reset until the supply and the selected primary clock can be trusted. It runs a chain of up to three waits. The first is a fixed power-up wait counted in reference ticks. The second is an oscillator warm-up that counts rising edges of the raw oscillator signal. The third is a phase-locked-loop settle wait, also counted in reference ticks. A separate short controller-ready wait runs alongside the chain. The oscillator mode code decides which stages of the chain apply.

Execution is released only when the chain has finished and the ready wait has expired. The oscillator-stable flag goes high when the chain alone is complete. Power-on reset can arrive at any moment. It clears every counter and the flag, and the sequence then restarts from the first stage.

Top module: `boot_hold_seq`

## Requirements
- R1: While `por` is high, `rst_hold` is 1 and `osc_stable` and `exec_go` are 0, whatever the other inputs do. When `por` is released, every count begins again from zero.
- R2: When `pwrt_off` is 0, the first stage lasts `PWRT_TICKS` pulses of `ref_tick`. When `pwrt_off` is 1, the first stage is skipped. Oscillator edges that arrive during this stage are not counted.
- R3: For the mode codes 0 (low-power crystal), 1 (standard crystal), 2 (high-speed crystal) and 3 (high-speed crystal with PLL), the warm-up stage ends after `OST_EDGES` rising edges of `osc_in`. Reference ticks do not advance this stage.
- R4: For mode code 3 only, a settle stage of `PLL_TICKS` reference ticks follows the warm-up stage.
- R5: For the mode codes 4 to 7 (external clock, RC and internal oscillator variants), the chain has no oscillator stage. The chain completes as soon as the first stage is over, or at once if the first stage is skipped.
- R6: `osc_stable` goes to 1 only after every stage that applies to the mode has finished. It then stays at 1 until the next reset.
- R7: The ready wait starts when reset is released. It runs in parallel with the chain and ends after `READY_TICKS` reference ticks.
- R8: `exec_go` is 1 only when both the chain and the ready wait are complete. `rst_hold` is always the inverse of `exec_go`.
- R9: The edge counter stops at its terminal count. Further edges of `osc_in` leave `osc_stable` and `exec_go` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sampling clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| pwrt_off | input | 1 | Configuration bit: 0 enables the power-up wait, 1 skips it |
| osc_mode | input | 3 | Primary oscillator mode code (0 to 7) |
| ref_tick | input | 1 | Single-cycle reference tick that times the tick-based waits |
| osc_in | input | 1 | Raw oscillator signal, asynchronous to `clk` |
| rst_hold | output | 1 | Internal reset hold, active high |
| osc_stable | output | 1 | All applicable chain stages are complete |
| exec_go | output | 1 | Permission to start execution |

## Verification
The bench builds the block with `PWRT_TICKS`=5, `OST_EDGES`=16, `PLL_TICKS`=4 and `READY_TICKS`=3. These small values let every stage boundary be reached edge by edge. The bench stops one edge or one tick short of each boundary and then crosses it. With these values the ready wait is shorter than the power-up wait and longer than an empty chain, so both orders of completion occur. The small edge count also makes it cheap to send more edges than the counter needs, which exercises saturation. It also makes it cheap to send edges during the power-up stage, which must not be counted.

// File: rtl/boot_hold_seq.sv
module boot_hold_seq #(
  parameter int PWRT_TICKS  = 66,
  parameter int OST_EDGES   = 1024,
  parameter int PLL_TICKS   = 2,
  parameter int READY_TICKS = 1
) (
  input  logic       clk,
  input  logic       por,
  input  logic       pwrt_off,
  input  logic [2:0] osc_mode,
  input  logic       ref_tick,
  input  logic       osc_in,
  output logic       rst_hold,
  output logic       osc_stable,
  output logic       exec_go
);

  localparam int MAXT = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int OW   = $clog2(OST_EDGES + 1);
  localparam int RW   = $clog2(READY_TICKS + 1);
  localparam logic [TW-1:0] PWRT_LAST = TW'(PWRT_TICKS - 1);
  localparam logic [TW-1:0] PLL_LAST  = TW'(PLL_TICKS - 1);
  localparam logic [OW-1:0] OST_TOP   = OW'(OST_EDGES);
  localparam logic [RW-1:0] RDY_TOP   = RW'(READY_TICKS);

  typedef enum logic [1:0] {ST_PWRT, ST_OST, ST_PLL, ST_DONE} stage_t;

  stage_t          stage;
  logic [TW-1:0]   tcnt;
  logic [OW-1:0]   ecnt;
  logic [RW-1:0]   rcnt;
  logic [2:0]      osc_sync;
  logic            osc_rise;
  logic            need_ost;
  logic            need_pll;
  logic            ost_full;
  logic            rdy_done;
  stage_t          after_pwrt;
  stage_t          after_ost;

  assign need_ost   = ~osc_mode[2];
  assign need_pll   = (osc_mode == 3'd3);
  assign osc_rise   = osc_sync[1] & ~osc_sync[2];
  assign ost_full   = (ecnt == OST_TOP);
  assign rdy_done   = (rcnt == RDY_TOP);
  assign after_pwrt = need_ost ? ST_OST : ST_DONE;
  assign after_ost  = need_pll ? ST_PLL : ST_DONE;

  always_ff @(posedge clk or posedge por) begin
    if (por) osc_sync <= '0;
    else     osc_sync <= {osc_sync[1:0], osc_in};
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      stage <= ST_PWRT;
      tcnt  <= '0;
      ecnt  <= '0;
    end else begin
      case (stage)
        ST_PWRT: begin
          if (pwrt_off) begin
            stage <= after_pwrt;
            tcnt  <= '0;
          end else if (ref_tick) begin
            if (tcnt == PWRT_LAST) begin
              stage <= after_pwrt;
              tcnt  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_OST: begin
          if (ost_full) stage <= after_ost;
          else if (osc_rise) ecnt <= ecnt + 1'b1;
        end
        ST_PLL: begin
          if (ref_tick) begin
            if (tcnt == PLL_LAST) begin
              stage <= ST_DONE;
              tcnt  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: stage <= ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por)                       rcnt <= '0;
    else if (ref_tick && !rdy_done) rcnt <= rcnt + 1'b1;
  end

  assign osc_stable = (stage == ST_DONE);
  assign exec_go    = osc_stable & rdy_done;
  assign rst_hold   = ~exec_go;

endmodule

// File: rtl/boot_hold_seq_chk.sv
module boot_hold_seq_chk (
  input logic       clk,
  input logic       por,
  input logic [2:0] osc_mode,
  input logic       ref_tick,
  input logic       rst_hold,
  input logic       osc_stable,
  input logic       exec_go
);

  always @(posedge clk) begin
    if (por) begin
      AST_RESET_CLEARS: assert (rst_hold && !osc_stable && !exec_go); // R1
    end
  end

  AST_EXEC_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (por)
    exec_go |-> osc_stable); // R8

  AST_STABLE_STICKS: assert property (@(posedge clk) disable iff (por)
    osc_stable |=> osc_stable); // R6

  AST_EXEC_STICKS: assert property (@(posedge clk) disable iff (por)
    exec_go |=> exec_go); // R9

  AST_PLL_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (por)
    ($rose(osc_stable) && osc_mode == 3'd3) |-> $past(ref_tick)); // R4

endmodule

bind boot_hold_seq boot_hold_seq_chk u_chk (
  .clk(clk), .por(por), .osc_mode(osc_mode), .ref_tick(ref_tick),
  .rst_hold(rst_hold), .osc_stable(osc_stable), .exec_go(exec_go)
);

// File: tb/boot_hold_seq_tb.sv
module boot_hold_seq_tb;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       pwrt_off = 1'b1;
  logic [2:0] osc_mode = 3'd4;
  logic       ref_tick = 1'b0;
  logic       osc_in = 1'b0;
  logic       rst_hold, osc_stable, exec_go;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    string req;
    bit    stable;
    bit    go;
  } exp_t;

  exp_t exp_q[$];
  event smp;

  always #10 clk = ~clk;

  boot_hold_seq #(.PWRT_TICKS(5), .OST_EDGES(16), .PLL_TICKS(4), .READY_TICKS(3)) u_dut (
    .clk(clk), .por(por), .pwrt_off(pwrt_off), .osc_mode(osc_mode),
    .ref_tick(ref_tick), .osc_in(osc_in),
    .rst_hold(rst_hold), .osc_stable(osc_stable), .exec_go(exec_go)
  );

  initial begin : monitor
    exp_t e;
    forever begin
      @(smp);
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        total++;
        if (osc_stable !== e.stable || exec_go !== e.go || rst_hold !== !e.go) begin
          bad++;
          $display("FAIL %s: stable/go/hold actual=%b%b%b expected=%b%b%b",
                   e.req, osc_stable, exec_go, rst_hold, e.stable, e.go, !e.go);
        end
      end
    end
  end

  task automatic expect_now(string req, bit s, bit g);
    exp_t e;
    repeat (6) @(negedge clk);
    e.req = req; e.stable = s; e.go = g;
    exp_q.push_back(e);
    ->smp;
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_in = 1'b1;
      @(negedge clk) osc_in = 1'b0;
    end
  endtask

  task automatic restart(bit off, logic [2:0] mode);
    @(negedge clk);
    por = 1'b1; pwrt_off = off; osc_mode = mode;
    expect_now("R1", 1'b0, 1'b0);
    @(negedge clk) por = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    restart(1'b1, 3'd4);
    expect_now("R5", 1'b1, 1'b0);
    ticks(2);
    expect_now("R7", 1'b1, 1'b0);
    ticks(1);
    expect_now("R8", 1'b1, 1'b1);

    restart(1'b1, 3'd1);
    expect_now("R3", 1'b0, 1'b0);
    ticks(4);
    expect_now("R3", 1'b0, 1'b0);
    edges(15);
    expect_now("R3", 1'b0, 1'b0);
    edges(1);
    expect_now("R6", 1'b1, 1'b1);
    edges(20);
    expect_now("R9", 1'b1, 1'b1);

    restart(1'b0, 3'd3);
    edges(20);
    expect_now("R2", 1'b0, 1'b0);
    ticks(4);
    expect_now("R2", 1'b0, 1'b0);
    ticks(1);
    edges(15);
    expect_now("R3", 1'b0, 1'b0);
    edges(1);
    expect_now("R4", 1'b0, 1'b0);
    ticks(3);
    expect_now("R4", 1'b0, 1'b0);
    ticks(1);
    expect_now("R4", 1'b1, 1'b1);

    restart(1'b0, 3'd6);
    ticks(3);
    restart(1'b0, 3'd6);
    ticks(4);
    expect_now("R1", 1'b0, 1'b0);
    ticks(1);
    expect_now("R2", 1'b1, 1'b1);

    restart(1'b0, 3'd2);
    ticks(5);
    expect_now("R2", 1'b0, 1'b0);
    edges(16);
    expect_now("R3", 1'b1, 1'b1);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule